// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block carries out one external memory or peripheral access at a time on behalf of an upstream address decoder. The decoder presents a request together with the timing profile of the target device: its chip-select index, its wait-state count, its data-float count, its read protocol and its write-lane style. The sequencer then drives the chip selects, the read strobe, the write strobes, the byte-lane enables and the write-data enable. It adds programmed and externally requested wait cycles and puts idle bus cycles in front of an access when the previous one requires them.

The block runs on a clock at twice the bus rate. Each bus cycle is made of two fast-clock halves, so strobe edges can fall in the middle of a bus cycle. An internal phase bit, cleared by reset, marks the halves. Bus-cycle decisions are taken on the fast edge that ends a second half, which is the bus clock rising edge. A request is held, with its fields stable, until `done` is seen. `done` is high for the one fast cycle that forms the second half of the access's last bus cycle. On the edge that ends that cycle, the sequencer retires the access and treats whatever request is present as the next one, so back-to-back accesses need no dead cycle.

A request flagged as internal does not touch the external pins. It takes one bus cycle and counts toward any pending idle requirement.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While reset is high and after it is released with no request, every `cs_n` bit, `rd_n`, `we_n`, `wrl_n`, `wrh_n`, `lbe_n` and `ube_n` are 1, and `done` and `data_oe` are 0.
- R2: An external access with programmed wait count W lasts 1+W bus cycles (2+2W fast cycles of chip select low). A request value above MAX_WS (8) is treated as MAX_WS.
- R3: `ext_hold_n` is sampled on each bus-cycle boundary inside an access. When it is low, the bus cycle then starting is an added cycle and the wait counter is frozen. With W=0 the single cycle is already the last when it starts, so a hold raised during that cycle has no effect.
- R4: A standard read (`req_early`=0) drives `rd_n` low from the second half of the first bus cycle until the end of the access.
- R5: An early read (`req_early`=1) drives `rd_n` low for the whole access. Back-to-back early reads to the same device keep `rd_n` low with no gap.
- R6: A write strobe falls at the start of the second half of the first bus cycle. For a one-cycle access it rises at the end. For a longer access it rises half a bus cycle before the end. No write strobe is ever low together with `rd_n`.
- R7: With `req_bytewr`=0 (byte-select style), writes use `we_n`. `lbe_n` follows `req_be[0]` (low byte) and `ube_n` follows `req_be[1]` (high byte) for the whole access. `wrl_n` and `wrh_n` stay 1.
- R8: With `req_bytewr`=1 (byte-write style), the write strobe appears on `wrl_n` when `req_be[0]` is set and on `wrh_n` when `req_be[1]` is set. `we_n`, `lbe_n` and `ube_n` stay 1, and reads use `rd_n` alone.
- R9: An external access to a chip select other than that of the previous external access waits one idle bus cycle, unless the previous access was programmed with nonzero wait states.
- R10: An early read that follows an external write waits one idle bus cycle. Read-then-write and same-type pairs get no such cycle.
- R11: After an external read with float count F, a write, or a read to a different chip select, cannot start until F bus cycles have passed. Internal access cycles in between count toward F.
- R12: When several idle rules apply, the idle time is the largest single requirement, not their sum. Internal accesses are never delayed by these rules.
- R13: `done` is high for exactly one fast cycle per request. An internal request completes in one bus cycle with no pin activity. `data_oe` is high for the whole of an external write and low otherwise.
- R14: During an external access exactly the `cs_n` bit indexed by `req_cs` is low, for the whole access, and it is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_ext | input | 1 | 1 external access, 0 internal access |
| req_wr | input | 1 | 1 write, 0 read |
| req_cs | input | CSW (3) | Chip-select index |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| req_ws | input | WSW (4) | Programmed wait states, clamped to MAX_WS |
| req_tdf | input | TW (3) | Data-float cycles after a read |
| req_early | input | 1 | Early read protocol for this device |
| req_bytewr | input | 1 | Byte-write lane style (else byte-select) |
| ext_hold_n | input | 1 | External wait request, active low |
| done | output | 1 | One fast-cycle completion pulse |
| cs_n | output | NCS (8) | Chip selects, active low |
| rd_n | output | 1 | Read strobe |
| we_n | output | 1 | Write strobe, byte-select style |
| wrl_n | output | 1 | Low-byte write strobe, byte-write style |
| wrh_n | output | 1 | High-byte write strobe, byte-write style |
| lbe_n | output | 1 | Low-byte lane enable |
| ube_n | output | 1 | High-byte lane enable |
| data_oe | output | 1 | Write-data drive enable |

## Verification
The bench sweeps pairs of accesses over read/write order, protocol, same or other device, zero or nonzero wait states, three float counts and zero to two internal accesses in between. It compares the idle cycles in front of every access with a maximum computed from the rules. A design that summed the rules, or that ignored internal cycles, would show too many idle cycles. One that dropped the wait-state exemption would add a spurious chip-select cycle. A second sweep covers every wait value up to 15 with and without external holds. This catches a missing clamp, a counter that kept running during a hold, or a hold honoured on a one-cycle access. Strobe low-time counts and the strobe level in the completion cycle reveal a write strobe that stays low to the end of a long access, or a standard read that starts early. Chained early reads to one device reveal a read strobe that blips between accesses.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INT  = 2'd1,
    ST_EXT  = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic rd_n;
    logic we_n;
    logic wrl_n;
    logic wrh_n;
    logic lbe_n;
    logic ube_n;
    logic oe;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{rd_n: 1'b1, we_n: 1'b1, wrl_n: 1'b1,
                                     wrh_n: 1'b1, lbe_n: 1'b1, ube_n: 1'b1,
                                     oe: 1'b0};
endpackage

// File: rtl/xbs_gap_track.sv
// Tracks the idle requirements left behind by the last external access and
// tells whether a proposed external access may start on this bus boundary.
module xbs_gap_track #(
  parameter int CSW = 3,
  parameter int TW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,     // a non-external bus cycle just ended
  input  logic           load,     // an external access just ended
  input  logic [CSW-1:0] ld_cs,
  input  logic           ld_wr,
  input  logic           ld_wsz,   // finished access had zero programmed waits
  input  logic [TW-1:0]  ld_tdf,
  input  logic [CSW-1:0] q_cs,
  input  logic           q_wr,
  input  logic           q_early,
  output logic           blocked
);
  logic           csc_q, csc_d;
  logic           ta_q, ta_d;
  logic [TW-1:0]  fl_q, fl_d;
  logic [CSW-1:0] lcs_q, lcs_d;

  always_comb begin
    csc_d = csc_q;
    ta_d  = ta_q;
    fl_d  = fl_q;
    lcs_d = lcs_q;
    if (load) begin
      csc_d = ld_wsz;
      ta_d  = ld_wr;
      fl_d  = ld_wr ? '0 : ld_tdf;
      lcs_d = ld_cs;
    end else if (tick) begin
      csc_d = 1'b0;
      ta_d  = 1'b0;
      fl_d  = (fl_q != '0) ? fl_q - TW'(1) : '0;
    end
    // each rule is a countdown; waiting until all applicable ones hit zero
    // applies the largest of them
    blocked = (csc_d && (q_cs != lcs_d)) ||
              (ta_d && q_early && !q_wr) ||
              ((fl_d != '0) && (q_wr || (q_cs != lcs_d)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csc_q <= 1'b0;
      ta_q  <= 1'b0;
      fl_q  <= '0;
      lcs_q <= '0;
    end else begin
      csc_q <= csc_d;
      ta_q  <= ta_d;
      fl_q  <= fl_d;
      lcs_q <= lcs_d;
    end
  end
endmodule

// File: rtl/xbs_strobe_gen.sv
// Decodes the pin levels for one fast-clock half from the sequencer state.
module xbs_strobe_gen
  import xbs_pkg::*;
(
  input  logic       act,
  input  logic       half2,
  input  logic       first,
  input  logic       last,
  input  logic       wr,
  input  logic       early,
  input  logic       bytewr,
  input  logic [1:0] be,
  output pin_set_t   pins
);
  logic lead, trail, rd_on, wstb;

  always_comb begin
    lead  = first && !half2;
    trail = last && !first && half2;
    rd_on = act && !wr && (early || !lead);
    wstb  = act && wr && !lead && !trail;
    pins.rd_n  = !rd_on;
    pins.we_n  = !(wstb && !bytewr);
    pins.wrl_n = !(wstb && bytewr && be[0]);
    pins.wrh_n = !(wstb && bytewr && be[1]);
    pins.lbe_n = !(act && !bytewr && be[0]);
    pins.ube_n = !(act && !bytewr && be[1]);
    pins.oe    = act && wr;
  end
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbs_pkg::*;
#(
  parameter int NCS     = 8,
  parameter int MAX_WS  = 8,
  parameter int MAX_TDF = 7,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int WSW = $clog2(MAX_WS + 1),
  localparam int TW  = $clog2(MAX_TDF + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_ext,
  input  logic           req_wr,
  input  logic [CSW-1:0] req_cs,
  input  logic [1:0]     req_be,
  input  logic [WSW-1:0] req_ws,
  input  logic [TW-1:0]  req_tdf,
  input  logic           req_early,
  input  logic           req_bytewr,
  input  logic           ext_hold_n,
  output logic           done,
  output logic [NCS-1:0] cs_n,
  output logic           rd_n,
  output logic           we_n,
  output logic           wrl_n,
  output logic           wrh_n,
  output logic           lbe_n,
  output logic           ube_n,
  output logic           data_oe
);
  seq_st_e        st_q, st_d;
  logic           ph_q;
  logic           first_q, first_d, last_q, last_d;
  logic [WSW-1:0] w_q, w_d, ws_eff;
  logic [CSW-1:0] cs_q, cs_d;
  logic           wr_q, wr_d, early_q, early_d, bw_q, bw_d, wsz_q, wsz_d;
  logic [1:0]     be_q, be_d;
  logic [TW-1:0]  tdf_q, tdf_d;
  logic           fin, start_ext, start_int, gap_block;
  logic [WSW:0]   step;
  pin_set_t       pins_q, pins_d;
  logic [NCS-1:0] cs_n_q, cs_n_d;
  logic           done_q, done_d;

  // one bus-cycle step of the wait counter: {last, next count}
  function automatic logic [WSW:0] wstep(input logic [WSW-1:0] w, input logic hold_n);
    if (!hold_n)        return {1'b0, w};
    else if (w == '0)   return {1'b1, w};
    else                return {1'b0, w - WSW'(1)};
  endfunction

  assign ws_eff    = (req_ws > WSW'(MAX_WS)) ? WSW'(MAX_WS) : req_ws;
  assign fin       = ph_q && ((st_q != ST_EXT) || last_q);
  assign start_ext = fin && req_valid && req_ext && !gap_block;
  assign start_int = fin && req_valid && !req_ext;

  xbs_gap_track #(.CSW(CSW), .TW(TW)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .tick    (fin && (st_q != ST_EXT)),
    .load    (fin && (st_q == ST_EXT)),
    .ld_cs   (cs_q),
    .ld_wr   (wr_q),
    .ld_wsz  (wsz_q),
    .ld_tdf  (tdf_q),
    .q_cs    (req_cs),
    .q_wr    (req_wr),
    .q_early (req_early),
    .blocked (gap_block)
  );

  always_comb begin
    st_d = st_q;  first_d = first_q;  last_d = last_q;  w_d = w_q;
    cs_d = cs_q;  wr_d = wr_q;  be_d = be_q;  early_d = early_q;
    bw_d = bw_q;  wsz_d = wsz_q;  tdf_d = tdf_q;
    step = '0;
    if (start_ext) begin
      st_d    = ST_EXT;
      cs_d    = req_cs;
      wr_d    = req_wr;
      be_d    = req_be;
      early_d = req_early;
      bw_d    = req_bytewr;
      wsz_d   = (ws_eff == '0);
      tdf_d   = req_tdf;
      first_d = 1'b1;
      step    = wstep(ws_eff, ext_hold_n);
      last_d  = step[WSW];
      w_d     = step[WSW-1:0];
    end else if (start_int) begin
      st_d = ST_INT;
    end else if (fin) begin
      st_d = ST_IDLE;
    end else if (ph_q && (st_q == ST_EXT)) begin
      first_d = 1'b0;
      step    = wstep(w_q, ext_hold_n);
      last_d  = step[WSW];
      w_d     = step[WSW-1:0];
    end
    done_d = !ph_q && ((st_d == ST_INT) || ((st_d == ST_EXT) && last_d));
  end

  xbs_strobe_gen u_strb (
    .act    (st_d == ST_EXT),
    .half2  (!ph_q),
    .first  (first_d),
    .last   (last_d),
    .wr     (wr_d),
    .early  (early_d),
    .bytewr (bw_d),
    .be     (be_d),
    .pins   (pins_d)
  );

  for (genvar g = 0; g < NCS; g++) begin : g_csel
    assign cs_n_d[g] = !((st_d == ST_EXT) && (cs_d == CSW'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;  ph_q <= 1'b0;  first_q <= 1'b0;  last_q <= 1'b0;
      w_q    <= '0;  cs_q <= '0;  wr_q <= 1'b0;  be_q <= '0;
      early_q <= 1'b0;  bw_q <= 1'b0;  wsz_q <= 1'b0;  tdf_q <= '0;
      pins_q <= PINS_IDLE;  cs_n_q <= '1;  done_q <= 1'b0;
    end else begin
      st_q   <= st_d;  ph_q <= !ph_q;  first_q <= first_d;  last_q <= last_d;
      w_q    <= w_d;  cs_q <= cs_d;  wr_q <= wr_d;  be_q <= be_d;
      early_q <= early_d;  bw_q <= bw_d;  wsz_q <= wsz_d;  tdf_q <= tdf_d;
      pins_q <= pins_d;  cs_n_q <= cs_n_d;  done_q <= done_d;
    end
  end

  assign done    = done_q;
  assign cs_n    = cs_n_q;
  assign rd_n    = pins_q.rd_n;
  assign we_n    = pins_q.we_n;
  assign wrl_n   = pins_q.wrl_n;
  assign wrh_n   = pins_q.wrh_n;
  assign lbe_n   = pins_q.lbe_n;
  assign ube_n   = pins_q.ube_n;
  assign data_oe = pins_q.oe;
endmodule

// File: rtl/xbus_cycle_seq_chk.sv
module xbus_cycle_seq_chk #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic [NCS-1:0] cs_n,
  input logic           rd_n,
  input logic           we_n,
  input logic           wrl_n,
  input logic           wrh_n,
  input logic           lbe_n,
  input logic           ube_n,
  input logic           data_oe
);
  logic rst_seen;
  always @(posedge clk) rst_seen <= rst;

  // R1
  always @(negedge clk)
    if (rst_seen)
      reset_state_chk: assert ((&cs_n) && rd_n && we_n && wrl_n && wrh_n &&
                               lbe_n && ube_n && !done && !data_oe)
        else $error("pins not idle after reset");

  // R14
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !wrl_n || !wrh_n) |-> (rd_n && !(&cs_n)));

  // R4
  rd_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !(&cs_n));

  // R13
  oe_write_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (rd_n && !(&cs_n)));

  // R7
  bsel_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (wrl_n && wrh_n));

  // R8
  bwr_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrl_n || !wrh_n) |-> (lbe_n && ube_n && we_n));
endmodule

bind xbus_cycle_seq xbus_cycle_seq_chk #(.NCS(NCS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .done    (done),
  .cs_n    (cs_n),
  .rd_n    (rd_n),
  .we_n    (we_n),
  .wrl_n   (wrl_n),
  .wrh_n   (wrh_n),
  .lbe_n   (lbe_n),
  .ube_n   (ube_n),
  .data_oe (data_oe)
);

// File: tb/xbus_cycle_seq_test.sv
module xbus_cycle_seq_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_ext = 1'b0, req_wr = 1'b0;
  logic [2:0] req_cs = '0;
  logic [1:0] req_be = '0;
  logic [3:0] req_ws = '0;
  logic [2:0] req_tdf = '0;
  logic       req_early = 1'b0, req_bytewr = 1'b0, hold_n = 1'b1;
  logic       done, rd_n, we_n, wrl_n, wrh_n, lbe_n, ube_n, data_oe;
  logic [7:0] cs_n;

  int errs = 0, checks = 0;
  bit have_last = 0, l_wr = 0, l_wsz = 0;
  int l_cs = 0, l_tdf = 0, elapsed = 0;

  always #(CLK_P/2) clk = ~clk;

  xbus_cycle_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ext(req_ext),
    .req_wr(req_wr), .req_cs(req_cs), .req_be(req_be), .req_ws(req_ws),
    .req_tdf(req_tdf), .req_early(req_early), .req_bytewr(req_bytewr),
    .ext_hold_n(hold_n), .done(done), .cs_n(cs_n), .rd_n(rd_n),
    .we_n(we_n), .wrl_n(wrl_n), .wrh_n(wrh_n), .lbe_n(lbe_n),
    .ube_n(ube_n), .data_oe(data_oe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // idle bus cycles owed before an external access, from R9..R12 rules
  task automatic gap_model(input int cs, input bit wr, input bit early,
                           output int g, output string tag);
    int c, t, f, m, n;
    c = 0; t = 0; f = 0;
    if (have_last) begin
      if (l_wsz && cs != l_cs) c = 1;
      if (early && !wr && l_wr) t = 1;
      if (!l_wr && (wr || cs != l_cs)) f = l_tdf;
    end
    m = c;
    if (t > m) m = t;
    if (f > m) m = f;
    g = m - elapsed;
    if (g < 0) g = 0;
    n = (c > 0 ? 1 : 0) + (t > 0 ? 1 : 0) + (f > 0 ? 1 : 0);
    if (n > 1)      tag = "R12 largest idle rule";
    else if (f > 0) tag = "R11 float idle";
    else if (t > 0) tag = "R10 turnaround idle";
    else            tag = "R9 select-change idle";
  endtask

  task automatic run_acc(input bit ext, input bit wr, input int cs, input bit [1:0] be,
                         input int ws, input int tdf, input bit early, input bit bw,
                         input int hc, input bit chk_idle);
    int g, wse, tt, cyc, k, n_act, n_idle, n_rd, n_we, n_wl, n_wh, n_lb, n_ub, n_oe, bad, sexp;
    bit d_rd, d_we, seen;
    string gtag;
    cyc = 0; k = 0; n_act = 0; n_idle = 0; n_rd = 0; n_we = 0; n_wl = 0; n_wh = 0;
    n_lb = 0; n_ub = 0; n_oe = 0; bad = 0; d_rd = 0; d_we = 0; seen = 0;
    if (ext) gap_model(cs, wr, early, g, gtag);
    else begin g = 0; gtag = "R12 internal not delayed"; end
    req_valid = 1; req_ext = ext; req_wr = wr; req_cs = cs[2:0]; req_be = be;
    req_ws = ws[3:0]; req_tdf = tdf[2:0]; req_early = early; req_bytewr = bw;
    forever begin
      @(negedge clk);
      cyc++;
      if (cs_n != 8'hFF) begin
        if (cs_n != ~(8'h01 << cs)) bad++;
        if (hc > 0 && k == 0) hold_n = 1'b0;
        if (hc > 0 && k == 2*hc) hold_n = 1'b1;
        k++; n_act++;
      end else n_idle++;
      if (!rd_n) n_rd++;
      if (!we_n) n_we++;
      if (!wrl_n) n_wl++;
      if (!wrh_n) n_wh++;
      if (!lbe_n) n_lb++;
      if (!ube_n) n_ub++;
      if (data_oe) n_oe++;
      if (done) begin
        seen = 1; d_rd = !rd_n; d_we = !(we_n && wrl_n && wrh_n);
        break;
      end
      if (cyc > 600) break;
    end
    hold_n = 1'b1;
    chk(seen, "R13 completion pulse seen", int'(seen), 1);
    wse = (ws > 8) ? 8 : ws;
    tt  = 1 + wse + ((wse > 0) ? hc : 0);
    if (ext) begin
      chk(n_act == 2*tt, "R2 R3 access length (fast cycles)", n_act, 2*tt);
      if (chk_idle) chk(n_idle == 2*g, gtag, n_idle, 2*g);
      chk(bad == 0, "R14 only selected chip select low", bad, 0);
      chk(n_oe == (wr ? 2*tt : 0), "R13 write data enable", n_oe, wr ? 2*tt : 0);
      chk(n_lb == ((!bw && be[0]) ? 2*tt : 0), "R7 R8 low lane enable", n_lb, (!bw && be[0]) ? 2*tt : 0);
      chk(n_ub == ((!bw && be[1]) ? 2*tt : 0), "R7 R8 high lane enable", n_ub, (!bw && be[1]) ? 2*tt : 0);
      if (!wr) begin
        sexp = early ? 2*tt : 2*tt - 1;
        chk(n_rd == sexp, early ? "R5 early read strobe" : "R4 standard read strobe", n_rd, sexp);
        chk(d_rd, "R4 R5 read strobe held to end", int'(d_rd), 1);
        chk(n_we + n_wl + n_wh == 0, "R6 no write strobe on read", n_we + n_wl + n_wh, 0);
      end else begin
        sexp = (tt == 1) ? 1 : 2*tt - 2;
        chk(n_rd == 0, "R6 no read strobe on write", n_rd, 0);
        chk(n_we == (bw ? 0 : sexp), "R7 we_n strobe length", n_we, bw ? 0 : sexp);
        chk(n_wl == ((bw && be[0]) ? sexp : 0), "R8 wrl_n strobe length", n_wl, (bw && be[0]) ? sexp : 0);
        chk(n_wh == ((bw && be[1]) ? sexp : 0), "R8 wrh_n strobe length", n_wh, (bw && be[1]) ? sexp : 0);
        if (!bw || be != 2'b00)
          chk(d_we == (tt == 1), "R6 write strobe in final half", int'(d_we), int'(tt == 1));
      end
      have_last = 1; l_cs = cs; l_wr = wr; l_wsz = (wse == 0); l_tdf = tdf; elapsed = 0;
    end else begin
      chk(n_act == 0 && n_idle == 2, "R13 internal access one bus cycle", n_idle, 2);
      chk(n_rd + n_we + n_wl + n_wh + n_oe == 0, "R13 internal access pins quiet",
          n_rd + n_we + n_wl + n_wh + n_oe, 0);
      elapsed++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int rot;
    repeat (4) @(negedge clk);
    chk(cs_n == 8'hFF && rd_n && we_n && wrl_n && wrh_n && lbe_n && ube_n && !done && !data_oe,
        "R1 pins idle in reset", int'(cs_n), 255);
    @(negedge clk); rst = 0;
    repeat (5) @(negedge clk);
    chk(cs_n == 8'hFF && rd_n && we_n && !done && !data_oe,
        "R1 pins idle after reset", int'(cs_n), 255);
    chk(wrl_n && wrh_n && lbe_n && ube_n, "R1 lane pins idle after reset",
        int'({wrl_n, wrh_n, lbe_n, ube_n}), 15);

    run_acc(1, 0, 0, 2'b11, 1, 0, 0, 0, 0, 0);
    rot = 0;
    // pair sweep for idle rules R9..R12
    for (int a_wr = 0; a_wr < 2; a_wr++)
      for (int b_wr = 0; b_wr < 2; b_wr++)
        for (int b_er = 0; b_er < 2; b_er++)
          for (int same = 0; same < 2; same++)
            for (int aw = 0; aw < 2; aw++)
              for (int ti = 0; ti < 3; ti++)
                for (int ni = 0; ni < 3; ni++) begin
                  int csa, csb, tdf;
                  csa = rot % 8;
                  csb = same ? csa : (csa + 1 + rot % 3) % 8;
                  tdf = (ti == 0) ? 0 : (ti == 1) ? 3 : 7;
                  run_acc(1, a_wr[0], csa, 2'(rot % 4), aw * 2, tdf, rot[2], rot[1],
                          aw ? rot % 3 : 0, 1);
                  for (int i = 0; i < ni; i++) run_acc(0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
                  run_acc(1, b_wr[0], csb, 2'(3 - rot % 4), rot % 4, rot % 8, b_er[0], rot[0], 0, 1);
                  rot++;
                end
    // wait-count sweep including clamp and holds (R2 R3 R6 R7 R8)
    for (int ws = 0; ws < 16; ws++)
      for (int h = 0; h < 3; h++)
        for (int m = 0; m < 4; m++)
          run_acc(1, m[0], 5, 2'b11 - 2'(m % 3), ws, 2, 1, m[1], h, 1);
    // chained early reads to one device (R5)
    for (int i = 0; i < 6; i++) run_acc(1, 0, 2, 2'b01, 0, 5, 1, 0, 0, 1);
    req_valid = 0;
    repeat (10) @(negedge clk);
    chk(cs_n == 8'hFF && rd_n && !done, "R1 pins idle when no request", int'(cs_n), 255);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule